// File: doc/BRIEF.md
# Byte-Wide Double-Data-Rate Link Transmitter

This block takes bytes from user logic in the local clock domain and sends them over an 8-bit double-data-rate link as 16-byte words. Bytes are written with a strobe into a 32-entry synchronous FIFO. A back-pressure output rises as the FIFO nears full. The forwarded link clock runs at half the local clock rate and changes level with every byte, so one byte leaves the block on each local cycle. Data, forwarded clock and direction outputs all come straight from flops, which keeps skew between clock and data small.

A word starts only once all 16 of its bytes are buffered, so a word never stalls partway through. With the check input high, the block appends a 17th byte to each word. That byte is the modulo-256 sum of the 16 data bytes. The same enable is meant to drive the matching receiver. With the burst-mode input low, runs of back-to-back words are capped at 64 and then broken by an idle cycle. With it high, words may follow each other without limit. A sticky timeout flag reports that data has been waiting too long without being sent. Only a one-cycle clear pulse lowers it.

Top module: `bytelink_tx`

## Requirements
- R1: The FIFO holds 32 bytes. A write strobe stores a byte unless 32 are already held, in which case that byte is dropped. Bytes leave on the link in the order they were accepted.
- R2: `bp_o` is high exactly while the FIFO holds 28 or more bytes (depth minus a slack of 4).
- R3: A word starts only when at least 16 bytes are buffered. Its 16 data bytes then leave on 16 consecutive local cycles with no pause.
- R4: Each transmitted byte comes with exactly one level change of `link_clk_o`, and `link_data_o` changes only when the clock changes. The first byte of every word comes with a rising edge. Between words the clock rests low, and after a checked word it falls on the cycle following the check byte.
- R5: With `chk_en` high, each word is followed by a check byte equal to the modulo-256 sum of its 16 data bytes. With it low, a word is exactly 16 bytes.
- R6: With `unlimited` low, after 64 back-to-back words exactly one idle cycle comes before the next word. With it high, words follow back to back for as long as data is available.
- R7: `tmo_o` rises after 256 consecutive local cycles in which the FIFO holds data and nothing is sent. It stays high until `tmo_clr` is pulsed, drops on the cycle after the pulse, and does not rise again until a new full waiting run.
- R8: During and right after reset, `link_clk_o`, `link_data_o`, `tmo_o` and `bp_o` are 0. `link_dir_o` is 0 in reset and 1 (transmit) from the first clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, twice the link clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to queue |
| chk_en | input | 1 | Append a sum check byte to each word |
| unlimited | input | 1 | 1: unlimited bursts, 0: bursts of at most 64 words |
| tmo_clr | input | 1 | One-cycle pulse that clears the timeout flag |
| bp_o | output | 1 | Back-pressure; stop writing while high |
| link_clk_o | output | 1 | Forwarded link clock |
| link_data_o | output | 8 | Link data byte |
| link_dir_o | output | 1 | Link direction, 1 while transmitting |
| tmo_o | output | 1 | Sticky transmit timeout flag |

## Verification
The hardest condition to reach from the ports is a full FIFO. The transmitter drains a byte per cycle as soon as 16 are held, so a writer running at one byte per cycle never gets ahead of it. The stimulus therefore turns on the check byte, which makes each word take 18 cycles for only 16 pops, and writes every cycle while ignoring back-pressure. Occupancy then climbs by two per word until writes start being dropped. The bench follows occupancy as accepted writes minus data bytes seen on the link. It uses that count to predict both back-pressure and the exact surviving byte stream. The 64-word burst cap needs more than a thousand bytes of unbroken supply, which a writer that obeys back-pressure provides.

// File: rtl/bytelink_tx.sv
module bytelink_tx #(
  parameter int DEPTH       = 32,
  parameter int BP_SLACK    = 4,
  parameter int WORD_BYTES  = 16,
  parameter int BURST_WORDS = 64,
  parameter int TMO_CYCLES  = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       chk_en,
  input  logic       unlimited,
  input  logic       tmo_clr,
  output logic       bp_o,
  output logic       link_clk_o,
  output logic [7:0] link_data_o,
  output logic       link_dir_o,
  output logic       tmo_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(WORD_BYTES + 1);
  localparam int BW = $clog2(BURST_WORDS + 1);
  localparam int TW = $clog2(TMO_CYCLES + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic [SW-1:0] slot;
  logic [BW-1:0] bcnt;
  logic [TW-1:0] wcnt;
  logic [7:0]    data_q, sum_q;
  logic          busy, chk_q, clk_q, gap, tmo_q, dir_q;

  logic push, pop, can_start, send, chk_w, last, fire;
  logic [7:0] head;

  assign head      = mem[rptr];
  assign push      = wr_en && (count != (AW+1)'(DEPTH));
  assign can_start = !busy && !gap && !clk_q && (count >= (AW+1)'(WORD_BYTES));
  assign send      = busy || can_start;
  assign chk_w     = busy ? chk_q : chk_en;
  assign last      = send && (slot == (chk_w ? SW'(WORD_BYTES) : SW'(WORD_BYTES - 1)));
  assign pop       = send && (slot < SW'(WORD_BYTES));
  assign fire      = !send && (count != '0) && (wcnt == TW'(TMO_CYCLES - 1));

  assign bp_o        = count >= (AW+1)'(DEPTH - BP_SLACK);
  assign link_clk_o  = clk_q;
  assign link_data_o = data_q;
  assign link_dir_o  = dir_q;
  assign tmo_o       = tmo_q;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      chk_q  <= 1'b0;
      clk_q  <= 1'b0;
      slot   <= '0;
      data_q <= '0;
      sum_q  <= '0;
      dir_q  <= 1'b0;
    end else begin
      dir_q <= 1'b1;
      if (send) begin
        clk_q  <= ~clk_q;
        data_q <= pop ? head : sum_q;
        slot   <= last ? '0 : slot + 1'b1;
        busy   <= !last;
        chk_q  <= chk_w;
        if (pop) sum_q <= ((slot == '0) ? 8'd0 : sum_q) + head;
      end else if (clk_q) begin
        clk_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt <= '0;
      gap  <= 1'b0;
    end else if (!send) begin
      bcnt <= '0;
      gap  <= 1'b0;
    end else if (last) begin
      if (unlimited) begin
        bcnt <= '0;
      end else if (bcnt == BW'(BURST_WORDS - 1)) begin
        bcnt <= '0;
        gap  <= 1'b1;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt  <= '0;
      tmo_q <= 1'b0;
    end else begin
      if (send || count == '0) wcnt <= '0;
      else if (wcnt != TW'(TMO_CYCLES)) wcnt <= wcnt + 1'b1;
      if (fire) tmo_q <= 1'b1;
      else if (tmo_clr) tmo_q <= 1'b0;
    end
  end

  // R1
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));

  // R1
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == (AW+1)'(DEPTH) && !pop) |=> count == (AW+1)'(DEPTH));

  // R3
  start_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(count) >= (AW+1)'(WORD_BYTES));

  // R4
  data_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(link_clk_o) |-> $stable(link_data_o));

  // R7
  tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_o && !tmo_clr) |=> tmo_o);
endmodule

// File: tb/sim_bytelink_tx.sv
module sim_bytelink_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int BP_LEVEL = 28;
  localparam int TMO = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic chk_en = 1'b0;
  logic unlimited = 1'b0;
  logic tmo_clr = 1'b0;
  logic bp_o, link_clk_o, link_dir_o, tmo_o;
  logic [7:0] link_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  bytelink_tx u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .chk_en(chk_en), .unlimited(unlimited), .tmo_clr(tmo_clr),
    .bp_o(bp_o), .link_clk_o(link_clk_o), .link_data_o(link_data_o),
    .link_dir_o(link_dir_o), .tmo_o(tmo_o)
  );

  int checks = 0;
  int errors = 0;
  int mcount = 0;
  int pat = 0;
  logic [7:0] exp_q[$];
  int gaps[400];
  int widx = 0;
  int idle_run = 0;
  int bidx = 0;
  bit in_word = 0;
  bit ret_exp = 0;
  bit pclk = 0;
  logic [7:0] sum = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic observe();
    bit pushed, popped;
    logic [7:0] e;
    pushed = wr_en && (mcount != DEPTH);
    popped = 0;
    if (link_clk_o == pclk) begin
      if (in_word) chk(0, "R3 stall inside word", 0, 1);
      else if (ret_exp) chk(0, "R4 clock return after check byte", 0, 1);
      else idle_run++;
    end else if (!in_word && !link_clk_o) begin
      chk(ret_exp, "R4 falling edge outside word", 0, 1);
      ret_exp = 0;
    end else begin
      if (!in_word) begin
        gaps[widx] = idle_run;
        idle_run = 0;
        in_word = 1;
        bidx = 0;
        sum = 0;
      end
      if (bidx < 16) begin
        if (exp_q.size() == 0) begin
          chk(0, "R1 byte sent with nothing queued", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(link_data_o == e, "R1 byte order", link_data_o, e);
        end
        sum = sum + link_data_o;
        popped = 1;
      end else begin
        chk(link_data_o == sum, "R5 check byte", link_data_o, sum);
      end
      bidx++;
      if (bidx == (chk_en ? 17 : 16)) begin
        in_word = 0;
        widx++;
        ret_exp = chk_en;
      end
    end
    pclk = link_clk_o;
    if (pushed) exp_q.push_back(wr_data);
    mcount = mcount + int'(pushed) - int'(popped);
    chk(bp_o == (mcount >= BP_LEVEL), "R2 back-pressure", bp_o, mcount >= BP_LEVEL);
  endtask

  task automatic step();
    @(negedge clk);
    observe();
  endtask

  task automatic put_byte(input bit en);
    wr_en = en;
    wr_data = 8'(pat * 37 + 11);
    if (en) pat++;
  endtask

  task automatic stream(input int nbytes, input bit obey);
    int sent = 0;
    while (sent < nbytes) begin
      put_byte(obey ? !bp_o : 1'b1);
      if (wr_en) sent++;
      step();
    end
    wr_en = 0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((mcount >= 16 || in_word || ret_exp) && guard < 2000) begin
      step();
      guard++;
    end
    repeat (3) step();
  endtask

  task automatic burst_phase(input bit unl);
    int base;
    unlimited = unl;
    chk_en = 0;
    base = widx;
    stream(70 * 16, 1);
    drain();
    chk(widx - base == 70, "R6 word count", widx - base, 70);
    for (int k = 1; k < 70; k++) begin
      int expg;
      expg = (!unl && k == 64) ? 1 : 0;
      chk(gaps[base + k] == expg, unl ? "R6 unlimited gap" : "R6 limited gap", gaps[base + k], expg);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(link_clk_o == 0 && link_data_o == 0, "R8 link idle in reset", link_data_o, 0);
    chk(tmo_o == 0 && bp_o == 0 && link_dir_o == 0, "R8 flags in reset", tmo_o, 0);
    rst_n = 1;
    step();
    chk(link_dir_o == 1, "R8 direction after reset", link_dir_o, 1);
    chk(link_clk_o == 0 && tmo_o == 0, "R8 outputs after reset", link_clk_o, 0);

    for (int i = 0; i < 5; i++) begin
      put_byte(1);
      step();
    end
    wr_en = 0;
    repeat (TMO - 5) step();
    chk(tmo_o == 0, "R7 no early timeout", tmo_o, 0);
    chk(link_clk_o == 0 && !in_word, "R3 no start with 5 bytes", link_clk_o, 0);
    step();
    chk(tmo_o == 1, "R7 timeout fires", tmo_o, 1);
    repeat (10) step();
    chk(tmo_o == 1, "R7 timeout sticky", tmo_o, 1);
    tmo_clr = 1;
    step();
    tmo_clr = 0;
    chk(tmo_o == 0, "R7 clear", tmo_o, 0);
    repeat (20) step();
    chk(tmo_o == 0, "R7 no refire", tmo_o, 0);
    for (int i = 0; i < 11; i++) begin
      put_byte(1);
      step();
    end
    wr_en = 0;
    drain();
    chk(widx == 1 && mcount == 0, "R3 single word sent", widx, 1);

    chk_en = 1;
    unlimited = 1;
    stream(300, 0);
    drain();
    stream((16 - mcount % 16) % 16, 1);
    drain();
    chk(mcount == 0 && exp_q.size() == 0, "R1 FIFO drained", mcount, 0);
    tmo_clr = 1;
    step();
    tmo_clr = 0;
    step();

    burst_phase(0);
    burst_phase(1);
    chk(tmo_o == 0, "R7 no timeout while streaming", tmo_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R3 watchdog expired: got 0 expected 1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule